// File: doc/BRIEF.md
# SPI Status Flag Register

This block keeps the read-only status byte of an SPI peripheral. It has four event flags: receive-full, match, transmit-empty and mode-fault. Each flag has its own set event and its own clear rule. The shift engine, the DMA engine and the bus interface drive single-cycle strobes into the block. The block returns the assembled byte on `status_o`.

Software clears an event flag by reading the status byte while the flag is set, which arms the flag, and by reading the data register on a later cycle. When receive DMA is enabled, the receive-full flag instead clears on the DMA-done strobe, and CPU reads do not touch it. The transmit-empty flag follows the transmit buffer: it clears when software loads the buffer and sets when the shifter takes the contents.

Every flag is registered. A strobe in cycle N shows on `status_o` from cycle N+1.

Top module: `spi_status_reg`

## Requirements
- R1: Bit positions on `status_o` are receive-full at 7, match at 6, transmit-empty at 5 and mode-fault at 4. Bits 3..0 are always 0.
- R2: After reset `status_o` is 0x20.
- R3: A write strobe (`status_wr_i`), whatever its data, changes no flag.
- R4: `xfer_done_i` sets receive-full, `match_hit_i` sets match and `mode_fault_i` sets mode-fault, each visible one cycle after the strobe.
- R5: In CPU-clear mode, a status read that sees a flag set arms that flag. A data read on a later cycle then clears it. A status read and a data read in the same cycle, with no earlier arm, do not clear.
- R6: A data read with no arm leaves a set flag set. A data read always consumes the arm, so a further data read needs a new status read before it can clear.
- R7: With `rx_dma_en_i` high, receive-full clears on `rx_dma_done_i`. Status and data reads neither arm it nor clear it.
- R8: When a set event and a clear condition of the same flag fall in one cycle, the flag ends set.
- R9: `txbuf_load_i` clears transmit-empty and `txbuf_move_i` sets it. If both come in one cycle, the flag ends set.
- R10: Match and mode-fault always use the CPU-clear sequence, whatever the value of `rx_dma_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_done_i | input | 1 | Transfer complete strobe |
| match_hit_i | input | 1 | Receive match strobe |
| mode_fault_i | input | 1 | Mode-fault strobe |
| txbuf_load_i | input | 1 | Software wrote the transmit buffer |
| txbuf_move_i | input | 1 | Transmit buffer moved to the shifter |
| status_rd_i | input | 1 | Status byte read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| rx_dma_en_i | input | 1 | Receive DMA enabled |
| rx_dma_done_i | input | 1 | Receive DMA transfer done |
| status_wr_i | input | 1 | Write strobe to the status byte |
| status_wdata_i | input | 8 | Write data, discarded |
| status_o | output | 8 | Status byte |

## Verification
The bench checks the arm timing. A status read and a data read in the same cycle must not clear a flag. A design that arms combinationally would clear it too early. A design that never consumes the arm would clear on a second bare data read.

The bench also checks priority. It drives set and clear into the same cycle, and load and move into the same cycle. A design with the wrong priority would drop a completed transfer or report a full transmit buffer as empty.

In DMA mode the bench drives CPU reads and checks that receive-full holds. It also checks that match and mode-fault still clear by reads, so a design that applies the DMA enable to every flag would be caught. Random traffic is compared against a behavioural model on every cycle.

// File: rtl/spi_status_pkg.sv
package spi_status_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned BIT_RXF   = 7;
  localparam int unsigned BIT_MATCH = 6;
  localparam int unsigned BIT_TXE   = 5;
  localparam int unsigned BIT_MODF  = 4;
  localparam int unsigned N_ARMED   = 3;
  // index into the armed flag vector
  localparam int unsigned IDX_RXF   = 0;
  localparam int unsigned IDX_MATCH = 1;
  localparam int unsigned IDX_MODF  = 2;
  localparam logic [STAT_W-1:0] STAT_RESET = 8'h20;
endpackage

// File: rtl/spi_armed_flag.sv
module spi_armed_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic status_rd_i,
  input  logic data_rd_i,
  input  logic dma_sel_i,
  input  logic dma_done_i,
  output logic flag_o
);
  logic flag_q, arm_q;
  logic clr, arm_d;

  assign clr   = dma_sel_i ? dma_done_i : (data_rd_i & arm_q);
  // arm is taken only from a status read that sees the flag set; any data read consumes it
  assign arm_d = ~dma_sel_i & flag_q & ~data_rd_i & (arm_q | status_rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr);
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R4
  set_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R5
  armed_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_sel_i && arm_q && data_rd_i && !set_i) |=> !flag_q);
  // R6
  bare_read_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_sel_i && flag_q && !arm_q && !dma_done_i) |=> flag_q);
  // R7
  dma_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_sel_i && dma_done_i && !set_i) |=> !flag_q);
  // R7
  dma_no_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_sel_i |=> !arm_q);
endmodule

// File: rtl/spi_txe_flag.sv
module spi_txe_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic move_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b1;
    else         flag_q <= move_i | (flag_q & ~load_i);
  end

  assign flag_o = flag_q;

  // R9
  txe_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !move_i) |=> !flag_q);
  // R9
  txe_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    move_i |=> flag_q);
endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg
  import spi_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_done_i,
  input  logic              match_hit_i,
  input  logic              mode_fault_i,
  input  logic              txbuf_load_i,
  input  logic              txbuf_move_i,
  input  logic              status_rd_i,
  input  logic              data_rd_i,
  input  logic              rx_dma_en_i,
  input  logic              rx_dma_done_i,
  input  logic              status_wr_i,
  input  logic [STAT_W-1:0] status_wdata_i,
  output logic [STAT_W-1:0] status_o
);
  logic [N_ARMED-1:0] set_v, dsel_v, ddone_v, flag_v;
  logic               txe;

  always_comb begin
    set_v   = '0;
    dsel_v  = '0;
    ddone_v = '0;
    set_v[IDX_RXF]   = xfer_done_i;
    set_v[IDX_MATCH] = match_hit_i;
    set_v[IDX_MODF]  = mode_fault_i;
    // only receive-full follows the DMA path
    dsel_v[IDX_RXF]  = rx_dma_en_i;
    ddone_v[IDX_RXF] = rx_dma_done_i;
  end

  for (genvar i = 0; i < N_ARMED; i++) begin : g_flag
    spi_armed_flag u_flag (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       (set_v[i]),
      .status_rd_i (status_rd_i),
      .data_rd_i   (data_rd_i),
      .dma_sel_i   (dsel_v[i]),
      .dma_done_i  (ddone_v[i]),
      .flag_o      (flag_v[i])
    );
  end

  spi_txe_flag u_txe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (txbuf_load_i),
    .move_i (txbuf_move_i),
    .flag_o (txe)
  );

  always_comb begin
    status_o            = '0;
    status_o[BIT_RXF]   = flag_v[IDX_RXF];
    status_o[BIT_MATCH] = flag_v[IDX_MATCH];
    status_o[BIT_TXE]   = txe;
    status_o[BIT_MODF]  = flag_v[IDX_MODF];
  end

  logic quiet;
  assign quiet = !(xfer_done_i | match_hit_i | mode_fault_i | txbuf_load_i |
                   txbuf_move_i | data_rd_i | rx_dma_done_i);

  // R1
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3:0] == 4'h0);
  // R3
  write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_wr_i && quiet && (status_wdata_i != status_o)) |=> $stable(status_o));
  // R10
  match_no_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[BIT_MATCH] && rx_dma_done_i && !data_rd_i) |=> status_o[BIT_MATCH]);
endmodule

// File: tb/spi_status_reg_test.sv
module spi_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer, mhit, mfault, load, move, srd, drd, dma_en, dma_done, wr;
  logic [7:0] wdata;
  logic [7:0] status;

  int checks = 0;
  int fails  = 0;
  bit timeout = 0;

  always #5 clk = ~clk;

  spi_status_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .xfer_done_i(xfer), .match_hit_i(mhit),
    .mode_fault_i(mfault), .txbuf_load_i(load), .txbuf_move_i(move),
    .status_rd_i(srd), .data_rd_i(drd), .rx_dma_en_i(dma_en),
    .rx_dma_done_i(dma_done), .status_wr_i(wr), .status_wdata_i(wdata),
    .status_o(status)
  );

  // reference model: f[0]=rx full, f[1]=match, f[2]=mode fault
  bit f[3];
  bit a[3];
  bit txe_m;

  function automatic logic [7:0] model_byte();
    return {f[0], f[1], txe_m, f[2], 4'h0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (f[i]) begin f[i] = 0; a[i] = 0; end
      txe_m = 1;
    end else begin
      bit ev[3];
      ev[0] = xfer; ev[1] = mhit; ev[2] = mfault;
      for (int i = 0; i < 3; i++) begin
        bool_step(i, ev[i]);
      end
      if (move) txe_m = 1;
      else if (load) txe_m = 0;
    end
  end

  task automatic bool_step(int i, bit ev);
    bit by_dma;
    bit cleared;
    by_dma = (i == 0) && dma_en;
    if (by_dma) begin
      cleared = dma_done;
      a[i] = 0;
    end else begin
      cleared = drd && a[i];
      if (drd) a[i] = 0;
      else if (srd && f[i]) a[i] = 1;
    end
    if (ev) f[i] = 1;
    else if (cleared) f[i] = 0;
    if (!f[i]) a[i] = 0;
  endtask

  string tag = "R2";

  // R1 R3 R4 R5 R6 R7 R8 R9 R10: every cycle compared with the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (status !== model_byte()) begin
        fails++;
        $display("FAIL %s model compare: got %02h expected %02h at %0t", tag, status, model_byte(), $time);
      end
    end
  end

  task automatic expect_val(logic [7:0] exp, string req);
    checks++;
    if (status !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, status, exp);
    end
  endtask

  task automatic idle_all();
    {xfer, mhit, mfault, load, move, srd, drd, dma_done, wr} = '0;
    wdata = 8'h00;
  endtask

  // drive strobes for one cycle, then return at the negedge where the result shows
  task automatic pulse(bit px, bit pm, bit pf, bit pl, bit pv, bit ps, bit pd, bit pdd);
    {xfer, mhit, mfault, load, move, srd, drd, dma_done} = {px, pm, pf, pl, pv, ps, pd, pdd};
    @(negedge clk);
    idle_all();
  endtask

  initial begin
    #1000000;
    timeout = 1;
  end

  initial begin
    idle_all();
    dma_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R2"; expect_val(8'h20, "R2 reset value");

    tag = "R4"; pulse(1,0,0,0,0,0,0,0); expect_val(8'hA0, "R4 rx full set");
    tag = "R6"; pulse(0,0,0,0,0,0,1,0); expect_val(8'hA0, "R6 bare data read keeps flag");
    tag = "R5"; pulse(0,0,0,0,0,1,0,0); pulse(0,0,0,0,0,0,1,0);
    expect_val(8'h20, "R5 status then data clears");
    pulse(1,0,0,0,0,0,0,0);
    pulse(0,0,0,0,0,1,1,0); expect_val(8'hA0, "R5 same-cycle reads do not clear");

    tag = "R3";
    wr = 1; wdata = 8'hFF; @(negedge clk); wr = 1; wdata = 8'h00; @(negedge clk); idle_all();
    expect_val(8'hA0, "R3 writes ignored");

    tag = "R8"; pulse(0,0,0,0,0,1,0,0); pulse(1,0,0,0,0,0,1,0);
    expect_val(8'hA0, "R8 set wins over clear");
    tag = "R6"; pulse(0,0,0,0,0,0,1,0); expect_val(8'hA0, "R6 arm consumed");

    tag = "R7"; dma_en = 1;
    pulse(0,0,0,0,0,1,0,0); pulse(0,0,0,0,0,0,1,0);
    expect_val(8'hA0, "R7 reads ignored in DMA mode");
    pulse(0,0,0,0,0,0,0,1); expect_val(8'h20, "R7 DMA done clears");
    pulse(1,0,0,0,0,0,0,1); expect_val(8'hA0, "R8 set wins over DMA done");
    pulse(0,0,0,0,0,0,0,1); expect_val(8'h20, "R7 DMA done clears again");

    tag = "R9";
    pulse(0,0,0,1,0,0,0,0); expect_val(8'h00, "R9 load clears tx empty");
    pulse(0,0,0,0,1,0,0,0); expect_val(8'h20, "R9 move sets tx empty");
    pulse(0,0,0,1,1,0,0,0); expect_val(8'h20, "R9 move wins over load");

    tag = "R10";
    pulse(0,1,1,0,0,0,0,0); expect_val(8'h70, "R4 match and mode fault set");
    pulse(0,0,0,0,0,0,0,1); expect_val(8'h70, "R10 DMA done leaves match and fault");
    pulse(0,0,0,0,0,1,0,0); pulse(0,0,0,0,0,0,1,0);
    expect_val(8'h20, "R10 CPU sequence clears match and fault in DMA mode");
    dma_en = 0;

    tag = "R1";
    pulse(1,1,1,0,0,0,0,0); expect_val(8'hF0, "R1 bit layout all flags");

    tag = "R1/R3-R10 random";
    for (int n = 0; n < 3000 && !timeout; n++) begin
      xfer     = ($urandom % 10) == 0;
      mhit     = ($urandom % 14) == 0;
      mfault   = ($urandom % 18) == 0;
      load     = ($urandom % 6) == 0;
      move     = ($urandom % 6) == 0;
      srd      = ($urandom % 4) == 0;
      drd      = ($urandom % 4) == 0;
      dma_done = ($urandom % 8) == 0;
      wr       = ($urandom % 8) == 0;
      wdata    = 8'($urandom);
      if (($urandom % 64) == 0) dma_en = ~dma_en;
      @(negedge clk);
    end
    idle_all();
    @(negedge clk);

    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule